// File: doc/BRIEF.md
# DFI Software Command Injector

This block lets software place one DDR command at a time onto phase 0 of a DFI bus during memory bring-up. Through a small Wishbone slave, software loads a command (chip select, write enable, column strobe, row strobe), a row/column address and a bank address into holding registers. A write to the issue register then puts that command on the DFI command lines for exactly one clock cycle.

The same register bank drives the static DRAM pins: clock enable, on-die termination and the active-low DRAM reset. A select bit in the control register picks the source of every DFI output. When it is clear, the software path drives them. When it is set, a hardware memory controller's DFI inputs pass straight through without change. The usual flow is as follows. Software runs the power-up and mode-register sequence with the select bit clear. It then sets the bit to hand the bus to the controller.

Top module: `dfi_cmd_injector`

## Requirements
- R1: A Wishbone request (cyc and stb high while ack is low) is acknowledged by ack going high in the next cycle. Ack is high for exactly one cycle.
- R2: Word address 0 selects control, 1 selects command, 2 selects issue, 3 selects address and 4 selects bank. Reads return the stored control bits [3:0], command bits [3:0], address and bank. Reads of issue, of indices 5 to 7, and of any address with bits above bit 2 set return 0, and writes to those unmapped locations change nothing. Read data is valid in the ack cycle.
- R3: After synchronous reset, all registers are 0. The software path is therefore selected, clock enable and termination are low, the DRAM reset output is low, and all four command lines are high.
- R4: The control register bits are: bit 0 select, bit 1 clock enable, bit 2 termination, bit 3 DRAM reset (active-low pin level). While select is 0, the three pins follow bits 1 to 3.
- R5: A write to issue with data bit 0 = 1 drives the command lines for exactly one cycle, in the ack cycle: cs_n = ~cmd[0], we_n = ~cmd[1], cas_n = ~cmd[2], ras_n = ~cmd[3]. A write to issue with bit 0 = 0 drives no command.
- R6: On the software path, outside an issue pulse, cs_n, ras_n, cas_n and we_n are all high.
- R7: On the software path, the DFI address and bank outputs carry the stored address and bank registers at all times.
- R8: While select is 1, every DFI output equals the corresponding hardware-controller input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc | input | 1 | Wishbone cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_adr | input | WB_AW | Wishbone word address |
| wb_dat_w | input | 32 | Wishbone write data |
| wb_dat_r | output | 32 | Wishbone read data |
| wb_ack | output | 1 | Wishbone acknowledge |
| hw_cs_n | input | 1 | Controller chip select |
| hw_ras_n | input | 1 | Controller row strobe |
| hw_cas_n | input | 1 | Controller column strobe |
| hw_we_n | input | 1 | Controller write enable |
| hw_address | input | ADDR_W | Controller address |
| hw_bank | input | BANK_W | Controller bank |
| hw_cke | input | 1 | Controller clock enable |
| hw_odt | input | 1 | Controller termination |
| hw_reset_n | input | 1 | Controller DRAM reset |
| dfi_cs_n | output | 1 | DFI chip select |
| dfi_ras_n | output | 1 | DFI row strobe |
| dfi_cas_n | output | 1 | DFI column strobe |
| dfi_we_n | output | 1 | DFI write enable |
| dfi_address | output | ADDR_W | DFI address |
| dfi_bank | output | BANK_W | DFI bank |
| dfi_cke | output | 1 | DFI clock enable |
| dfi_odt | output | 1 | DFI termination |
| dfi_reset_n | output | 1 | DFI DRAM reset |

## Verification
The assertions assume that a Wishbone master drops or renews its request after each ack. They also assume that the select bit does not change in the same cycle as an issue pulse. Both hold by construction, because every register write, including a change of select, needs its own accepted request. The stimulus uses a master that deasserts cyc and stb in the ack cycle and applies back-to-back accesses only through fresh requests. It randomizes the hardware-controller inputs on every cycle, so the pass-through and the software path are both compared against changing values.

// File: rtl/dfi_inj_pkg.sv
`timescale 1ns/1ps
package dfi_inj_pkg;

    localparam int WB_DW     = 32;
    localparam int REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        IDX_CTRL  = 3'd0,
        IDX_CMD   = 3'd1,
        IDX_ISSUE = 3'd2,
        IDX_ADDR  = 3'd3,
        IDX_BANK  = 3'd4
    } reg_idx_e;

    // bit order matters: software writes these positions
    typedef struct packed {
        logic dram_rst_n;   // bit 3
        logic term_en;      // bit 2
        logic clk_en;       // bit 1
        logic hw_sel;       // bit 0
    } ctrl_t;

    typedef struct packed {
        logic row_strobe;   // bit 3
        logic col_strobe;   // bit 2
        logic wr_en;        // bit 1
        logic chip_sel;     // bit 0
    } cmd_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } dfi_cmd_t;

    localparam dfi_cmd_t DFI_CMD_IDLE = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    function automatic dfi_cmd_t cmd_to_dfi(input cmd_t c);
        dfi_cmd_t d;
        d.cs_n  = ~c.chip_sel;
        d.ras_n = ~c.row_strobe;
        d.cas_n = ~c.col_strobe;
        d.we_n  = ~c.wr_en;
        return d;
    endfunction

endpackage

// File: rtl/dfi_inj_regs.sv
`timescale 1ns/1ps
module dfi_inj_regs
    import dfi_inj_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BANK_W = 3,
    parameter int WB_AW  = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_cyc,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [WB_AW-1:0]  wb_adr,
    input  logic [WB_DW-1:0]  wb_dat_w,
    output logic [WB_DW-1:0]  wb_dat_r,
    output logic              wb_ack,
    output ctrl_t             ctrl_o,
    output cmd_t              cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              fire_o
);
    localparam int HI_W = WB_AW - REG_IDX_W;

    logic              accept;
    logic              in_range;
    reg_idx_e          idx;
    logic [WB_DW-1:0]  rd_val;

    assign accept   = wb_cyc & wb_stb & ~wb_ack;
    assign in_range = (wb_adr[WB_AW-1:REG_IDX_W] == {HI_W{1'b0}});
    assign idx      = reg_idx_e'(wb_adr[REG_IDX_W-1:0]);

    always_comb begin
        rd_val = '0;
        if (in_range) begin
            case (idx)
                IDX_CTRL: rd_val[3:0]        = ctrl_o;
                IDX_CMD:  rd_val[3:0]        = cmd_o;
                IDX_ADDR: rd_val[ADDR_W-1:0] = addr_o;
                IDX_BANK: rd_val[BANK_W-1:0] = bank_o;
                default:  rd_val             = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_ack   <= 1'b0;
            wb_dat_r <= '0;
            ctrl_o   <= '0;
            cmd_o    <= '0;
            addr_o   <= '0;
            bank_o   <= '0;
            fire_o   <= 1'b0;
        end else begin
            wb_ack <= accept;
            fire_o <= 1'b0;
            if (accept && !wb_we) begin
                wb_dat_r <= rd_val;
            end
            if (accept && wb_we && in_range) begin
                case (idx)
                    IDX_CTRL:  ctrl_o <= ctrl_t'(wb_dat_w[3:0]);
                    IDX_CMD:   cmd_o  <= cmd_t'(wb_dat_w[3:0]);
                    IDX_ISSUE: fire_o <= wb_dat_w[0];
                    IDX_ADDR:  addr_o <= wb_dat_w[ADDR_W-1:0];
                    IDX_BANK:  bank_o <= wb_dat_w[BANK_W-1:0];
                    default:   ;
                endcase
            end
        end
    end

    assert_ack_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc && wb_stb && !wb_ack) |=> wb_ack);
    assert_ack_single_R1: assert property (@(posedge clk) disable iff (rst)
        wb_ack |=> !wb_ack);
    assert_fire_single_R5: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> !fire_o);
endmodule

// File: rtl/dfi_inj_cmdgen.sv
`timescale 1ns/1ps
module dfi_inj_cmdgen
    import dfi_inj_pkg::*;
(
    input  logic     fire,
    input  cmd_t     cmd,
    output dfi_cmd_t dfi_cmd
);
    always_comb begin
        dfi_cmd = fire ? cmd_to_dfi(cmd) : DFI_CMD_IDLE;
    end
endmodule

// File: rtl/dfi_inj_mux.sv
`timescale 1ns/1ps
module dfi_inj_mux
    import dfi_inj_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BANK_W = 3
) (
    input  logic              use_hw,
    input  dfi_cmd_t          sw_cmd,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [BANK_W-1:0] sw_bank,
    input  ctrl_t             sw_ctrl,
    input  dfi_cmd_t          hw_cmd,
    input  logic [ADDR_W-1:0] hw_addr,
    input  logic [BANK_W-1:0] hw_bank,
    input  logic              hw_cke,
    input  logic              hw_odt,
    input  logic              hw_rst_n,
    output dfi_cmd_t          out_cmd,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BANK_W-1:0] out_bank,
    output logic              out_cke,
    output logic              out_odt,
    output logic              out_rst_n
);
    always_comb begin
        if (use_hw) begin
            out_cmd   = hw_cmd;
            out_addr  = hw_addr;
            out_bank  = hw_bank;
            out_cke   = hw_cke;
            out_odt   = hw_odt;
            out_rst_n = hw_rst_n;
        end else begin
            out_cmd   = sw_cmd;
            out_addr  = sw_addr;
            out_bank  = sw_bank;
            out_cke   = sw_ctrl.clk_en;
            out_odt   = sw_ctrl.term_en;
            out_rst_n = sw_ctrl.dram_rst_n;
        end
    end
endmodule

// File: rtl/dfi_cmd_injector.sv
`timescale 1ns/1ps
module dfi_cmd_injector
    import dfi_inj_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BANK_W = 3,
    parameter int WB_AW  = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_cyc,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [WB_AW-1:0]  wb_adr,
    input  logic [31:0]       wb_dat_w,
    output logic [31:0]       wb_dat_r,
    output logic              wb_ack,
    input  logic              hw_cs_n,
    input  logic              hw_ras_n,
    input  logic              hw_cas_n,
    input  logic              hw_we_n,
    input  logic [ADDR_W-1:0] hw_address,
    input  logic [BANK_W-1:0] hw_bank,
    input  logic              hw_cke,
    input  logic              hw_odt,
    input  logic              hw_reset_n,
    output logic              dfi_cs_n,
    output logic              dfi_ras_n,
    output logic              dfi_cas_n,
    output logic              dfi_we_n,
    output logic [ADDR_W-1:0] dfi_address,
    output logic [BANK_W-1:0] dfi_bank,
    output logic              dfi_cke,
    output logic              dfi_odt,
    output logic              dfi_reset_n
);
    ctrl_t             ctrl_q;
    cmd_t              cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BANK_W-1:0] bank_q;
    logic              fire;
    dfi_cmd_t          sw_cmd;
    dfi_cmd_t          hw_cmd;
    dfi_cmd_t          out_cmd;

    assign hw_cmd = '{cs_n: hw_cs_n, ras_n: hw_ras_n, cas_n: hw_cas_n, we_n: hw_we_n};

    dfi_inj_regs #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .WB_AW(WB_AW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wb_cyc   (wb_cyc),
        .wb_stb   (wb_stb),
        .wb_we    (wb_we),
        .wb_adr   (wb_adr),
        .wb_dat_w (wb_dat_w),
        .wb_dat_r (wb_dat_r),
        .wb_ack   (wb_ack),
        .ctrl_o   (ctrl_q),
        .cmd_o    (cmd_q),
        .addr_o   (addr_q),
        .bank_o   (bank_q),
        .fire_o   (fire)
    );

    dfi_inj_cmdgen u_cmdgen (
        .fire    (fire),
        .cmd     (cmd_q),
        .dfi_cmd (sw_cmd)
    );

    dfi_inj_mux #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_mux (
        .use_hw    (ctrl_q.hw_sel),
        .sw_cmd    (sw_cmd),
        .sw_addr   (addr_q),
        .sw_bank   (bank_q),
        .sw_ctrl   (ctrl_q),
        .hw_cmd    (hw_cmd),
        .hw_addr   (hw_address),
        .hw_bank   (hw_bank),
        .hw_cke    (hw_cke),
        .hw_odt    (hw_odt),
        .hw_rst_n  (hw_reset_n),
        .out_cmd   (out_cmd),
        .out_addr  (dfi_address),
        .out_bank  (dfi_bank),
        .out_cke   (dfi_cke),
        .out_odt   (dfi_odt),
        .out_rst_n (dfi_reset_n)
    );

    assign dfi_cs_n  = out_cmd.cs_n;
    assign dfi_ras_n = out_cmd.ras_n;
    assign dfi_cas_n = out_cmd.cas_n;
    assign dfi_we_n  = out_cmd.we_n;

    // an accepted issue write on the software path shows the stored chip select next cycle
    assert_issue_drives_cs_R5: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc && wb_stb && !wb_ack && wb_we && wb_adr == WB_AW'(IDX_ISSUE)
         && wb_dat_w[0] && !ctrl_q.hw_sel)
        |=> (dfi_cs_n == !cmd_q.chip_sel));

    // software path with no pulse pending keeps every command line high
    assert_idle_lines_high_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.hw_sel && !fire) |-> (dfi_cs_n && dfi_ras_n && dfi_cas_n && dfi_we_n));

    // a pulse never lasts past the ack cycle on the bus
    assert_pulse_ends_R5: assert property (@(posedge clk) disable iff (rst)
        (wb_ack && !ctrl_q.hw_sel && !dfi_cs_n) |=> (ctrl_q.hw_sel || dfi_cs_n));
endmodule

// File: tb/dfi_cmd_injector_bench.sv
`timescale 1ns/1ps
module dfi_cmd_injector_bench;
    localparam int AW  = 14;
    localparam int BW  = 3;
    localparam int WAW = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wb_cyc = 0, wb_stb = 0, wb_we = 0;
    logic [WAW-1:0] wb_adr = '0;
    logic [31:0] wb_dat_w = '0;
    logic [31:0] wb_dat_r;
    logic wb_ack;
    logic hw_cs_n = 1, hw_ras_n = 1, hw_cas_n = 1, hw_we_n = 1;
    logic [AW-1:0] hw_address = '0;
    logic [BW-1:0] hw_bank = '0;
    logic hw_cke = 0, hw_odt = 0, hw_reset_n = 0;
    logic dfi_cs_n, dfi_ras_n, dfi_cas_n, dfi_we_n;
    logic [AW-1:0] dfi_address;
    logic [BW-1:0] dfi_bank;
    logic dfi_cke, dfi_odt, dfi_reset_n;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit compare_on = 0;

    // reference state
    logic [3:0] m_ctrl, m_cmd;
    logic [AW-1:0] m_addr;
    logic [BW-1:0] m_bank;
    logic m_fire, m_ack;
    logic [31:0] m_rd;

    dfi_cmd_injector #(.ADDR_W(AW), .BANK_W(BW), .WB_AW(WAW)) u_dfi_cmd_injector (
        .clk(clk), .rst(rst),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
        .hw_cs_n(hw_cs_n), .hw_ras_n(hw_ras_n), .hw_cas_n(hw_cas_n), .hw_we_n(hw_we_n),
        .hw_address(hw_address), .hw_bank(hw_bank), .hw_cke(hw_cke), .hw_odt(hw_odt),
        .hw_reset_n(hw_reset_n),
        .dfi_cs_n(dfi_cs_n), .dfi_ras_n(dfi_ras_n), .dfi_cas_n(dfi_cas_n), .dfi_we_n(dfi_we_n),
        .dfi_address(dfi_address), .dfi_bank(dfi_bank), .dfi_cke(dfi_cke), .dfi_odt(dfi_odt),
        .dfi_reset_n(dfi_reset_n)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_ctrl <= 0; m_cmd <= 0; m_addr <= 0; m_bank <= 0;
            m_fire <= 0; m_ack <= 0; m_rd <= 0;
        end else begin
            m_fire <= 0;
            m_ack  <= wb_cyc && wb_stb && !m_ack;
            if (wb_cyc && wb_stb && !m_ack) begin
                if (wb_we) begin
                    if (wb_adr == 0) m_ctrl <= wb_dat_w[3:0];
                    if (wb_adr == 1) m_cmd  <= wb_dat_w[3:0];
                    if (wb_adr == 2) m_fire <= wb_dat_w[0];
                    if (wb_adr == 3) m_addr <= wb_dat_w[AW-1:0];
                    if (wb_adr == 4) m_bank <= wb_dat_w[BW-1:0];
                end else begin
                    m_rd <= (wb_adr == 0) ? {28'd0, m_ctrl} :
                            (wb_adr == 1) ? {28'd0, m_cmd} :
                            (wb_adr == 3) ? 32'(m_addr) :
                            (wb_adr == 4) ? 32'(m_bank) : 32'd0;
                end
            end
        end
    end

    // drive controller inputs and compare every cycle away from the rising edge
    always @(negedge clk) begin
        {hw_cs_n, hw_ras_n, hw_cas_n, hw_we_n} = 4'($urandom);
        hw_address = AW'($urandom);
        hw_bank    = BW'($urandom);
        {hw_cke, hw_odt, hw_reset_n} = 3'($urandom);
        #1;
        if (compare_on) begin
            chk("R1", "ack", wb_ack, m_ack);
            if (m_ack) chk("R2", "read data", wb_dat_r, m_rd);
            if (m_ctrl[0]) begin
                chk("R8", "cmd lines", {dfi_cs_n, dfi_ras_n, dfi_cas_n, dfi_we_n},
                    {hw_cs_n, hw_ras_n, hw_cas_n, hw_we_n});
                chk("R8", "addr/bank", {dfi_address, dfi_bank}, {hw_address, hw_bank});
                chk("R8", "pins", {dfi_cke, dfi_odt, dfi_reset_n}, {hw_cke, hw_odt, hw_reset_n});
            end else begin
                if (m_fire)
                    chk("R5", "pulse", {dfi_cs_n, dfi_ras_n, dfi_cas_n, dfi_we_n},
                        {~m_cmd[0], ~m_cmd[3], ~m_cmd[2], ~m_cmd[1]});
                else
                    chk("R6", "idle lines", {dfi_cs_n, dfi_ras_n, dfi_cas_n, dfi_we_n}, 4'hF);
                chk("R7", "addr/bank", {dfi_address, dfi_bank}, {m_addr, m_bank});
                chk("R4", "pins", {dfi_cke, dfi_odt, dfi_reset_n}, {m_ctrl[1], m_ctrl[2], m_ctrl[3]});
            end
        end
    end

    task automatic wb_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = WAW'(idx); wb_dat_w = d;
        @(negedge clk);
        wb_cyc = 0; wb_stb = 0; wb_we = 0;
    endtask

    task automatic wb_read(input int idx, input logic [31:0] exp, input string req);
        @(negedge clk);
        wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = WAW'(idx);
        @(negedge clk);
        #1.5;
        chk(req, "readback", wb_dat_r, exp);
        wb_cyc = 0; wb_stb = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        #1.5;
        // R3: reset state at the ports
        chk("R3", "cmd lines", {dfi_cs_n, dfi_ras_n, dfi_cas_n, dfi_we_n}, 4'hF);
        chk("R3", "pins", {dfi_cke, dfi_odt, dfi_reset_n}, 3'b000);
        chk("R3", "addr/bank", {dfi_address, dfi_bank}, '0);
        chk("R3", "ack", wb_ack, 1'b0);
        rst = 0;
        compare_on = 1;
        wb_read(0, 32'h0, "R3");
        // R4: power-up pin sequence
        wb_write(0, 32'h0E);
        idle(2);
        wb_write(0, 32'h0C);
        wb_read(0, 32'hC, "R4");
        wb_write(0, 32'h0E);
        // R5: mode-register style command with all four lines
        wb_write(3, 32'h200);
        wb_write(4, 32'h2);
        wb_write(1, 32'h0F);
        wb_write(2, 32'h1);
        idle(2);
        wb_read(3, 32'h200, "R2");
        wb_read(4, 32'h2, "R2");
        wb_read(1, 32'hF, "R2");
        // R5: chip select plus write enable only
        wb_write(3, 32'h400);
        wb_write(4, 32'h0);
        wb_write(1, 32'h03);
        wb_write(2, 32'h1);
        wb_write(2, 32'h1);
        // R5: bit 0 clear issues nothing
        wb_write(2, 32'h0);
        wb_write(2, 32'h2);
        // R2: issue and unmapped locations read zero, unmapped writes ignored
        wb_read(2, 32'h0, "R2");
        wb_write(5, 32'hFF);
        wb_write(8, 32'h01);
        wb_read(5, 32'h0, "R2");
        wb_read(0, 32'hE, "R2");
        // R8: hand over to the controller
        wb_write(0, 32'h01);
        idle(20);
        wb_write(2, 32'h1);
        idle(5);
        wb_read(0, 32'h1, "R8");
        // back to software
        wb_write(0, 32'h0E);
        wb_write(1, 32'h0A);
        wb_write(2, 32'h1);
        idle(5);
        summary();
    end

    initial begin
        #20000;
        fails++;
        $display("FAIL watchdog expired: actual hung expected finish");
        summary();
    end
endmodule